// File: doc/BRIEF.md
# Masked Message Match Interrupt Unit

This block follows an infrared message decoder. Each time the decoder presents a finished raw message, the block stores the message and its bit length. It then compares the message against a 64-bit filter value, using a 64-bit mask that selects which bits take part. Three interrupt sources are kept as pending bits:

- a message has arrived;
- the masked message equals the filter;
- an edge pulse has been seen on the input.

Each source has its own enable. One combined interrupt line is driven from the pending sources that are enabled.

Software uses a small word-wide register interface. Through it, software programs the filter and the mask as a lower and an upper 32-bit word each, sets the enables, and clears pending bits by writing ones. It reads the arrival flag and the length from a status word and reads the stored message back. A mask of all zeros switches matching off completely. When software needs an interrupt only for a chosen message, it enables the match source and leaves the arrival source disabled.

Top module: `msg_match_irq`

## Requirements
- R1: After reset, every register reads 0, `pend_o` is 0 and `irq` is low.
- R2: Registers are 32 bits wide and are selected by `reg_addr`. Address 0 holds the filter low word, 1 the filter high word, 2 the mask low word and 3 the mask high word. Address 4 holds the enables in bits [2:0], and a read returns what was written.
- R3: When the mask is nonzero and every mask-selected message bit equals the filter bit, a `msg_valid` cycle sets pending bit 1 (match). The bit is visible from the next cycle.
- R4: If any mask-selected bit differs, match pending is not set. Bits outside the mask have no effect on the result.
- R5: When both mask words are zero, no message sets match pending.
- R6: A `msg_valid` cycle sets pending bit 0 (arrival) and status bit 0. It also stores the message, which reads at address 8 (low word) and address 9 (high word), and stores the length, which reads at status bits [13:8]. Status is at address 6.
- R7: An `edge_evt` cycle sets pending bit 2.
- R8: `irq` is high exactly when some pending bit has its enable bit set.
- R9: A pending bit latches while its enable is off. Setting the enable later raises `irq`.
- R10: Writing address 5 clears each pending bit whose write-data bit is 1 and leaves the rest unchanged. A read of address 5 returns the pending bits. An event in the same cycle as a clear keeps its bit set.
- R11: Writing status bit 0 as 0 clears the arrival flag, and writing it as 1 leaves the flag unchanged. The stored message stays readable afterwards. A `msg_valid` in the same cycle as the clear keeps the flag set.
- R12: The match is decided only in the `msg_valid` cycle. A later change to the filter or the mask does not change match pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | One-cycle strobe: a decoded message is present |
| msg_data | input | 64 | Decoded raw message |
| msg_len | input | 6 | Bit length of the message |
| edge_evt | input | 1 | One-cycle pulse for an input edge |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Combined interrupt |
| pend_o | output | 3 | Pending bits: 0 arrival, 1 match, 2 edge |

## Verification
Two functions can fall in the same cycle: a software clear and a hardware event. The first case is a write to the clear register with bit 0 set in the same cycle as `msg_valid`. The second is a status write that clears the arrival flag in the same cycle as `msg_valid`. The bench drives both inputs together in one cycle and then reads the ports. The event must survive in each case, so a message is never lost to a clear that software issued just before the message arrived.

// File: rtl/mmi_pkg.sv
package mmi_pkg;

    localparam int DATA_W = 64;
    localparam int REG_W  = 32;
    localparam int NSRC   = 3;
    localparam int ADDR_W = 4;
    localparam int LEN_W  = 6;

    localparam int SRC_ARRIVE = 0;
    localparam int SRC_MATCH  = 1;
    localparam int SRC_EDGE   = 2;

    localparam logic [ADDR_W-1:0] A_FILT_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_FILT_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'd6;
    localparam logic [ADDR_W-1:0] A_DATA_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_DATA_HI = 4'd9;

    localparam int STAT_LEN_LSB = 8;

    typedef struct packed {
        logic [DATA_W-1:0] filt;
        logic [DATA_W-1:0] mask;
        logic [NSRC-1:0]   en;
    } cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic              arrived;
    } cap_t;

endpackage

// File: rtl/mmi_cfg_regs.sv
module mmi_cfg_regs
    import mmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [DATA_W-1:0] filt,
    output logic [DATA_W-1:0] mask,
    output logic [NSRC-1:0]   en
);

    localparam int HI_W = DATA_W - REG_W;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                A_FILT_LO: cfg_d.filt[REG_W-1:0]      = wdata;
                A_FILT_HI: cfg_d.filt[DATA_W-1:REG_W] = wdata[HI_W-1:0];
                A_MASK_LO: cfg_d.mask[REG_W-1:0]      = wdata;
                A_MASK_HI: cfg_d.mask[DATA_W-1:REG_W] = wdata[HI_W-1:0];
                A_ENABLE:  cfg_d.en                   = wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign filt = cfg_q.filt;
    assign mask = cfg_q.mask;
    assign en   = cfg_q.en;

endmodule

// File: rtl/mmi_compare.sv
module mmi_compare
    import mmi_pkg::*;
#(
    parameter int LANE_W = REG_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] filt,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);

    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_eq;
    logic [LANES-1:0] lane_used;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] diff;
        assign diff         = (data[g*LANE_W +: LANE_W] ^ filt[g*LANE_W +: LANE_W])
                              & mask[g*LANE_W +: LANE_W];
        assign lane_eq[g]   = (diff == '0);
        assign lane_used[g] = |mask[g*LANE_W +: LANE_W];
    end

    assign hit = (&lane_eq) & (|lane_used);

endmodule

// File: rtl/mmi_pending.sv
module mmi_pending
    import mmi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] pend,
    output logic            irq
);

    logic [NSRC-1:0] pend_d, pend_q;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            pend_d[i] = set[i] | (pend_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
    assign irq  = |(pend_q & en);

endmodule

// File: rtl/msg_match_irq.sv
module msg_match_irq
    import mmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [DATA_W-1:0] msg_data,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              edge_evt,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic [NSRC-1:0]   pend_o
);

    localparam int HI_W   = DATA_W - REG_W;
    localparam int STAT_Z = REG_W - STAT_LEN_LSB - LEN_W;

    logic [DATA_W-1:0] filt_q;
    logic [DATA_W-1:0] mask_q;
    logic [NSRC-1:0]   en_q;
    logic              hit;
    logic [NSRC-1:0]   ev_set;
    logic [NSRC-1:0]   ev_clr;
    cap_t              cap_d, cap_q;

    mmi_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .filt  (filt_q),
        .mask  (mask_q),
        .en    (en_q)
    );

    mmi_compare u_cmp (
        .data (msg_data),
        .filt (filt_q),
        .mask (mask_q),
        .hit  (hit)
    );

    always_comb begin
        ev_set             = '0;
        ev_set[SRC_ARRIVE] = msg_valid;
        ev_set[SRC_MATCH]  = msg_valid & hit;
        ev_set[SRC_EDGE]   = edge_evt;
        ev_clr = (reg_we && reg_addr == A_CLEAR) ? reg_wdata[NSRC-1:0] : '0;
    end

    mmi_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (ev_clr),
        .en    (en_q),
        .pend  (pend_o),
        .irq   (irq)
    );

    // capture of the last message; arrival wins over a same-cycle status clear
    always_comb begin
        cap_d = cap_q;
        if (msg_valid) begin
            cap_d.data    = msg_data;
            cap_d.len     = msg_len;
            cap_d.arrived = 1'b1;
        end else if (reg_we && reg_addr == A_STATUS && !reg_wdata[0]) begin
            cap_d.arrived = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_comb begin
        case (reg_addr)
            A_FILT_LO: reg_rdata = filt_q[REG_W-1:0];
            A_FILT_HI: reg_rdata = {{(REG_W-HI_W){1'b0}}, filt_q[DATA_W-1:REG_W]};
            A_MASK_LO: reg_rdata = mask_q[REG_W-1:0];
            A_MASK_HI: reg_rdata = {{(REG_W-HI_W){1'b0}}, mask_q[DATA_W-1:REG_W]};
            A_ENABLE:  reg_rdata = {{(REG_W-NSRC){1'b0}}, en_q};
            A_CLEAR:   reg_rdata = {{(REG_W-NSRC){1'b0}}, pend_o};
            A_STATUS:  reg_rdata = {{STAT_Z{1'b0}}, cap_q.len,
                                    {(STAT_LEN_LSB-1){1'b0}}, cap_q.arrived};
            A_DATA_LO: reg_rdata = cap_q.data[REG_W-1:0];
            A_DATA_HI: reg_rdata = {{(REG_W-HI_W){1'b0}}, cap_q.data[DATA_W-1:REG_W]};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmi_checker.sv
module mmi_checker
    import mmi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic [DATA_W-1:0] msg_data,
    input logic              edge_evt,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0] filt_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [NSRC-1:0]   en_q,
    input logic              irq,
    input logic [NSRC-1:0]   pend_o
);

    // R3
    a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && mask_q != '0 && ((msg_data ^ filt_q) & mask_q) == '0)
        |=> pend_o[SRC_MATCH]);

    // R5
    a_r5_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && !pend_o[SRC_MATCH]) |=> !pend_o[SRC_MATCH]);

    // R6
    a_r6_arrival_sets: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> pend_o[SRC_ARRIVE]);

    // R7
    a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> pend_o[SRC_EDGE]);

    // R8
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & en_q) == '0) |-> !irq);

    // R10
    a_r10_clear_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CLEAR && reg_wdata[SRC_ARRIVE] && !msg_valid)
        |=> !pend_o[SRC_ARRIVE]);

    // R10
    a_r10_pend_only_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[SRC_EDGE] && !(reg_we && reg_addr == A_CLEAR)) |=> pend_o[SRC_EDGE]);

endmodule

bind msg_match_irq mmi_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .edge_evt  (edge_evt),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .filt_q    (filt_q),
    .mask_q    (mask_q),
    .en_q      (en_q),
    .irq       (irq),
    .pend_o    (pend_o)
);

// File: tb/msg_match_irq_test.sv
`timescale 1ns/1ps
module msg_match_irq_test;
    import mmi_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msg_valid = 1'b0;
    logic [DATA_W-1:0] msg_data = '0;
    logic [LEN_W-1:0]  msg_len = '0;
    logic              edge_evt = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq;
    logic [NSRC-1:0]   pend_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    msg_match_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .msg_len   (msg_len),
        .edge_evt  (edge_evt),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .pend_o    (pend_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [63:0] d, input logic [LEN_W-1:0] l);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d; msg_len = l;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic set_filter(input logic [63:0] f, input logic [63:0] m);
        wr(A_FILT_LO, f[31:0]);
        wr(A_FILT_HI, f[63:32]);
        wr(A_MASK_LO, m[31:0]);
        wr(A_MASK_HI, m[63:32]);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pend", pend_o, 0);
        check("R1 irq", irq, 0);
        for (int a = 0; a < 10; a++) begin
            rd(a[ADDR_W-1:0], v);
            check("R1 reg", v, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] v;
        set_filter(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0000_FFFF_0001);
        wr(A_ENABLE, 32'h5);
        rd(A_FILT_LO, v); check("R2 filt lo", v, 32'h9ABC_DEF0);
        rd(A_FILT_HI, v); check("R2 filt hi", v, 32'h1234_5678);
        rd(A_MASK_LO, v); check("R2 mask lo", v, 32'hFFFF_0001);
        rd(A_MASK_HI, v); check("R2 mask hi", v, 32'h0F0F_0000);
        rd(A_ENABLE, v);  check("R2 enable", v, 32'h5);
        wr(A_ENABLE, 0);
    endtask

    task automatic t_zero_mask();
        logic [31:0] v;
        set_filter(64'h0, 64'h0);
        send(64'h0, 6'd32);
        check("R5 no match on zero mask", pend_o[SRC_MATCH], 0);
        check("R6 arrival pend", pend_o[SRC_ARRIVE], 1);
        rd(A_CLEAR, v); check("R10 pend readback", v, 32'h1);
        wr(A_CLEAR, 32'h7);
        check("R10 cleared", pend_o, 0);
    endtask

    task automatic t_match();
        logic [31:0] v;
        set_filter(64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_0000_FFFF);
        send(64'hDEAD_1111_2222_4567, 6'd48);
        check("R3 match pend", pend_o[SRC_MATCH], 1);
        check("R4 unmasked ignored", pend_o[SRC_ARRIVE], 1);
        rd(A_DATA_LO, v); check("R6 data lo", v, 32'h2222_4567);
        rd(A_DATA_HI, v); check("R6 data hi", v, 32'hDEAD_1111);
        rd(A_STATUS, v);  check("R6 status", v, (32'd48 << STAT_LEN_LSB) | 1);
        check("R8 irq off while disabled", irq, 0);
        wr(A_CLEAR, 32'h7);
    endtask

    task automatic t_mismatch();
        send(64'hDEAD_1111_2222_4566, 6'd48);
        check("R4 low bit mismatch", pend_o[SRC_MATCH], 0);
        send(64'hDEAC_BEEF_0123_4567, 6'd48);
        check("R4 high bit mismatch", pend_o[SRC_MATCH], 0);
        wr(A_CLEAR, 32'h7);
    endtask

    task automatic t_latch_enable();
        send(64'hDEAD_0000_0000_4567, 6'd40);
        check("R9 latched while disabled", pend_o, 3'b011);
        check("R9 irq still low", irq, 0);
        wr(A_ENABLE, 32'h2);
        check("R9 irq after enable", irq, 1);
        wr(A_CLEAR, 32'h1);
        check("R10 other bit kept", pend_o, 3'b010);
        check("R8 irq match enabled", irq, 1);
        wr(A_CLEAR, 32'h2);
        check("R8 irq low after clear", irq, 0);
        wr(A_ENABLE, 0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        send(64'hAAAA_BBBB_CCCC_DDDD, 6'd20);
        wr(A_STATUS, 32'h1);
        rd(A_STATUS, v); check("R11 write 1 keeps flag", v[0], 1);
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, v); check("R11 write 0 clears flag", v[0], 0);
        rd(A_DATA_LO, v); check("R11 data still readable", v, 32'hCCCC_DDDD);
        wr(A_CLEAR, 32'h7);
    endtask

    task automatic t_edge();
        @(negedge clk); edge_evt = 1'b1;
        @(negedge clk); edge_evt = 1'b0;
        check("R7 edge pend", pend_o, 3'b100);
        check("R8 edge disabled", irq, 0);
        wr(A_ENABLE, 32'h4);
        check("R8 edge irq", irq, 1);
        wr(A_CLEAR, 32'h4);
        wr(A_ENABLE, 0);
    endtask

    task automatic t_late_filter();
        send(64'h0000_0000_0000_0001, 6'd16);
        check("R12 no match at strobe", pend_o[SRC_MATCH], 0);
        set_filter(64'h1, 64'h1);
        check("R12 later filter no effect", pend_o[SRC_MATCH], 0);
        wr(A_CLEAR, 32'h7);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 64'h5; msg_len = 6'd8;
        reg_we = 1'b1; reg_addr = A_CLEAR; reg_wdata = 32'h1;
        @(negedge clk);
        msg_valid = 1'b0; reg_we = 1'b0;
        check("R10 event beats clear", pend_o[SRC_ARRIVE], 1);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 64'h6;
        reg_we = 1'b1; reg_addr = A_STATUS; reg_wdata = 32'h0;
        @(negedge clk);
        msg_valid = 1'b0; reg_we = 1'b0;
        rd(A_STATUS, v); check("R11 arrival beats status clear", v[0], 1);
        rd(A_DATA_LO, v); check("R6 newest data", v, 32'h6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_zero_mask();
        t_match();
        t_mismatch();
        t_latch_enable();
        t_status();
        t_edge();
        t_late_filter();
        t_collision();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule